// File: doc/BRIEF.md
# Single-Precision Floating-Point Add/Subtract Pipeline

The block adds or subtracts two 32-bit binary floating-point words (1 sign bit, 8-bit exponent biased by 127, 23-bit fraction). When the subtract control is set, the sign of the second operand is inverted before the operation. Each operand is decoded into a significand and an effective exponent. Exponent field 0 gives a hidden bit of 0 with scale 2^-126. A field of all ones gives infinity when the fraction is zero and NaN when it is not. A normal operand has a hidden leading 1.

The datapath runs in three register stages and takes a new operation every cycle.
- The first stage sorts the operands by magnitude. It shifts the smaller significand right by the exponent difference and keeps guard, round and sticky bits.
- The second stage adds or subtracts the aligned significands.
- The third stage normalises left or right and rounds to nearest, ties to even. It renormalises when rounding carries out of the significand, then packs the result with overflow and underflow flags.

Top module: `fp32_addsub`

## Requirements
- R1: A result appears on `out_valid` exactly 3 clock edges after the edge that samples `in_valid`. One operation can be accepted on every cycle, and results leave in issue order. `ovf_flag` and `unf_flag` are 0 whenever `out_valid` is 0.
- R2: For finite operands, the result equals the exact sum a + b (or a - b when `op_sub` is 1), rounded to single precision. This holds for both signs and for either operand being the larger.
- R3: If the discarded part of the result is exactly half a unit in the last place, the result rounds to the neighbour whose fraction LSB (bit 0) is 0. A larger discarded part rounds away from zero in magnitude. A smaller one truncates.
- R4: When rounding carries out of the 24-bit significand, the fraction becomes 0 and the exponent field is incremented by one.
- R5: Cancellation normalises the result left and lowers the exponent to match. An exact zero result is +0 (0x00000000). The one exception is that both effective operands are negative zeros, for example (-0)+(-0): that gives -0 (0x80000000).
- R6: An operand with exponent field 0 is read as 0.fraction × 2^-126. A nonzero finite result too small for a normal number is returned with exponent field 0 and sets `unf_flag`. Every other result leaves `unf_flag` at 0.
- R7: A finite result whose rounded exponent reaches 255 is returned as infinity with the sign of the result (0x7F800000 or 0xFF800000) and sets `ovf_flag`. Every other result leaves `ovf_flag` at 0.
- R8: Infinity plus a finite value returns that infinity. Two infinities of the same effective sign return that infinity. Infinities of opposite effective sign return 0x7FC00000. No flag is set in any of these cases.
- R9: Any NaN operand (exponent field 255, fraction nonzero) makes the result exactly 0x7FC00000, with no flags set.
- R10: When the smaller operand lies entirely below the round position, it affects the result only through the sticky bit. It may still decide a rounding step in subtraction.
- R11: While `rst_n` is low, and right after it is released, `out_valid`, `ovf_flag` and `unf_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands valid this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sub | input | 1 | 1 selects a - b, 0 selects a + b |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Rounded result word |
| ovf_flag | output | 1 | Result overflowed to infinity |
| unf_flag | output | 1 | Result is a nonzero subnormal |

## Verification
The latency and NaN properties count three edges forward from an `in_valid` sample. They assume that `rst_n` stays high across that window and that operands are sampled only while `in_valid` is 1. The stimulus therefore holds reset low only before the first operation, and it changes operands and `in_valid` only on falling edges. The flag properties assume the output word is meaningful only while `out_valid` is 1. The stimulus includes back-to-back operations as well as spaced ones, so each result is tied to its own operation rather than to a neighbour's.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int GRS_W  = 3;
    localparam int ALN_W  = SIG_W + GRS_W;
    localparam int SUM_W  = ALN_W + 1;
    localparam int WIDE_W = 2 * ALN_W;
    localparam int SH_W   = $clog2(ALN_W + 1);
    localparam int XE_W   = EXP_W + 2;

    localparam logic [EXP_W-1:0]  EXP_MAX = '1;
    localparam logic [WORD_W-1:0] QNAN    = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic              vld;
        logic              spec;
        logic [WORD_W-1:0] spec_val;
        logic              zsgn;
        logic              sgn;
        logic              subop;
        logic [EXP_W-1:0]  exp;
        logic [ALN_W-1:0]  mb;
        logic [ALN_W-1:0]  ms;
    } align_t;

    typedef struct packed {
        logic              vld;
        logic              spec;
        logic [WORD_W-1:0] spec_val;
        logic              zsgn;
        logic              sgn;
        logic [EXP_W-1:0]  exp;
        logic [SUM_W-1:0]  sum;
    } sum_t;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] res;
        logic              ovf;
        logic              unf;
    } res_t;

    typedef struct packed {
        align_t s1;
        sum_t   s2;
        res_t   s3;
    } pipe_t;
endpackage

// File: rtl/fpa_align.sv
module fpa_align
    import fpa_pkg::*;
(
    input  logic              vld_i,
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  logic              sub_i,
    output align_t            al_o
);
    localparam logic [EXP_W-1:0] ALN_E = EXP_W'(ALN_W);
    localparam logic [EXP_W-1:0] ONE_E = EXP_W'(1);

    logic              sa, sb, a_big;
    logic [EXP_W-1:0]  ea, eb, e_big, e_sml, diff;
    logic [FRAC_W-1:0] fa, fb;
    logic              nan_a, nan_b, inf_a, inf_b;
    logic [SIG_W-1:0]  ma, mb, m_big, m_sml;
    logic [SH_W-1:0]   sh;
    logic [WIDE_W-1:0] wide_v, shifted;
    logic [ALN_W-1:0]  al_v;
    logic              stk;

    always_comb begin
        sa    = a_i[WORD_W-1];
        sb    = b_i[WORD_W-1] ^ sub_i;
        ea    = a_i[WORD_W-2:FRAC_W];
        eb    = b_i[WORD_W-2:FRAC_W];
        fa    = a_i[FRAC_W-1:0];
        fb    = b_i[FRAC_W-1:0];
        nan_a = (ea == EXP_MAX) && (fa != '0);
        nan_b = (eb == EXP_MAX) && (fb != '0);
        inf_a = (ea == EXP_MAX) && (fa == '0);
        inf_b = (eb == EXP_MAX) && (fb == '0);
        ma    = {ea != '0, fa};
        mb    = {eb != '0, fb};
        a_big = a_i[WORD_W-2:0] >= b_i[WORD_W-2:0];

        e_big = a_big ? ea : eb;
        e_sml = a_big ? eb : ea;
        if (e_big == '0) e_big = ONE_E;
        if (e_sml == '0) e_sml = ONE_E;
        m_big = a_big ? ma : mb;
        m_sml = a_big ? mb : ma;
        diff  = e_big - e_sml;
        sh    = (diff >= ALN_E) ? SH_W'(ALN_W) : diff[SH_W-1:0];

        wide_v  = {m_sml, {(WIDE_W-SIG_W){1'b0}}};
        shifted = wide_v >> sh;
        al_v    = shifted[WIDE_W-1:ALN_W];
        stk     = |shifted[ALN_W-1:0];

        al_o.vld   = vld_i;
        al_o.zsgn  = sa & sb;
        al_o.sgn   = a_big ? sa : sb;
        al_o.subop = sa ^ sb;
        al_o.exp   = e_big;
        al_o.mb    = {m_big, {GRS_W{1'b0}}};
        al_o.ms    = {al_v[ALN_W-1:1], al_v[0] | stk};

        al_o.spec     = 1'b1;
        al_o.spec_val = QNAN;
        if (nan_a || nan_b || (inf_a && inf_b && (sa != sb))) begin
            al_o.spec_val = QNAN;
        end else if (inf_a) begin
            al_o.spec_val = {sa, EXP_MAX, {FRAC_W{1'b0}}};
        end else if (inf_b) begin
            al_o.spec_val = {sb, EXP_MAX, {FRAC_W{1'b0}}};
        end else begin
            al_o.spec = 1'b0;
        end
    end
endmodule

// File: rtl/fpa_add.sv
module fpa_add
    import fpa_pkg::*;
(
    input  align_t al_i,
    output sum_t   sm_o
);
    always_comb begin
        sm_o.vld      = al_i.vld;
        sm_o.spec     = al_i.spec;
        sm_o.spec_val = al_i.spec_val;
        sm_o.zsgn     = al_i.zsgn;
        sm_o.sgn      = al_i.sgn;
        sm_o.exp      = al_i.exp;
        if (al_i.subop) sm_o.sum = {1'b0, al_i.mb} - {1'b0, al_i.ms};
        else            sm_o.sum = {1'b0, al_i.mb} + {1'b0, al_i.ms};
    end
endmodule

// File: rtl/fpa_round.sv
module fpa_round
    import fpa_pkg::*;
(
    input  sum_t sm_i,
    output res_t rs_o
);
    localparam logic [XE_W-1:0] ONE_X = XE_W'(1);
    localparam logic [XE_W-1:0] TOP_X = XE_W'(EXP_MAX);

    logic [SUM_W-1:0]  m;
    logic [XE_W-1:0]   e, lz, lim, sh, ne, eo;
    logic              found, g, r, s, up;
    logic [ALN_W-1:0]  norm;
    logic [SIG_W-1:0]  mant;
    logic [SIG_W:0]    mr;
    logic [FRAC_W-1:0] frac;

    always_comb begin
        m     = sm_i.sum;
        e     = {2'b00, sm_i.exp};
        lz    = '0;
        found = 1'b0;
        for (int i = ALN_W - 1; i >= 0; i--) begin
            if (!found) begin
                if (m[i]) found = 1'b1;
                else      lz    = lz + ONE_X;
            end
        end
        lim = e - ONE_X;
        sh  = (lz < lim) ? lz : lim;

        if (m[SUM_W-1]) begin
            norm = {m[SUM_W-1:2], m[1] | m[0]};
            ne   = e + ONE_X;
        end else begin
            norm = m[ALN_W-1:0] << sh;
            ne   = e - sh;
        end

        mant = norm[ALN_W-1:GRS_W];
        g    = norm[2];
        r    = norm[1];
        s    = norm[0];
        up   = g & (r | s | mant[0]);
        mr   = {1'b0, mant} + {{SIG_W{1'b0}}, up};
        eo   = norm[ALN_W-1] ? ne : '0;
        frac = mr[FRAC_W-1:0];
        if (mr[SIG_W]) begin
            eo   = eo + ONE_X;
            frac = mr[FRAC_W:1];
        end else if (!norm[ALN_W-1] && mr[FRAC_W]) begin
            eo = ONE_X;
        end

        rs_o.vld = sm_i.vld;
        rs_o.ovf = 1'b0;
        rs_o.unf = 1'b0;
        if (sm_i.spec) begin
            rs_o.res = sm_i.spec_val;
        end else if (m == '0) begin
            rs_o.res = {sm_i.zsgn, {(WORD_W-1){1'b0}}};
        end else if (eo >= TOP_X) begin
            rs_o.res = {sm_i.sgn, EXP_MAX, {FRAC_W{1'b0}}};
            rs_o.ovf = sm_i.vld;
        end else begin
            rs_o.res = {sm_i.sgn, eo[EXP_W-1:0], frac};
            rs_o.unf = sm_i.vld & (eo == '0);
        end
    end
endmodule

// File: rtl/fp32_addsub.sv
module fp32_addsub
    import fpa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              op_sub,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    output logic              ovf_flag,
    output logic              unf_flag
);
    pipe_t  pipe_d, pipe_q;
    align_t al_w;
    sum_t   sm_w;
    res_t   rs_w;

    fpa_align u_align (
        .vld_i (in_valid),
        .a_i   (op_a),
        .b_i   (op_b),
        .sub_i (op_sub),
        .al_o  (al_w)
    );

    fpa_add u_add (
        .al_i (pipe_q.s1),
        .sm_o (sm_w)
    );

    fpa_round u_round (
        .sm_i (pipe_q.s2),
        .rs_o (rs_w)
    );

    always_comb begin
        pipe_d    = pipe_q;
        pipe_d.s1 = al_w;
        pipe_d.s2 = sm_w;
        pipe_d.s3 = rs_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_valid = pipe_q.s3.vld;
    assign result    = pipe_q.s3.res;
    assign ovf_flag  = pipe_q.s3.ovf;
    assign unf_flag  = pipe_q.s3.unf;
endmodule

// File: rtl/fpa_chk.sv
module fpa_chk
    import fpa_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] op_a,
    input logic [WORD_W-1:0] op_b,
    input logic              out_valid,
    input logic [WORD_W-1:0] result,
    input logic              ovf_flag,
    input logic              unf_flag
);
    logic any_nan;
    assign any_nan = ((op_a[WORD_W-2:FRAC_W] == EXP_MAX) && (op_a[FRAC_W-1:0] != '0)) ||
                     ((op_b[WORD_W-2:FRAC_W] == EXP_MAX) && (op_b[FRAC_W-1:0] != '0));

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) in_valid |-> ##3 out_valid); // R1
    AST_FLAG_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> (!ovf_flag && !unf_flag)); // R1
    AST_OVF_INF: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ovf_flag) |-> (result[WORD_W-2:0] == {EXP_MAX, {FRAC_W{1'b0}}})); // R7
    AST_UNF_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && unf_flag) |-> (result[WORD_W-2:FRAC_W] == '0 && result[FRAC_W-1:0] != '0)); // R6
    AST_NAN_CANON: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && result[WORD_W-2:FRAC_W] == EXP_MAX && result[FRAC_W-1:0] != '0) |-> (result == QNAN)); // R9
    AST_NAN_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && any_nan) |-> ##3 (out_valid && result == QNAN && !ovf_flag && !unf_flag)); // R9
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(ovf_flag && unf_flag)); // R6
endmodule

bind fp32_addsub fpa_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .result    (result),
    .ovf_flag  (ovf_flag),
    .unf_flag  (unf_flag)
);

// File: tb/fp32_addsub_tb.sv
module fp32_addsub_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        op_sub = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        ovf_flag;
    logic        unf_flag;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    logic [33:0] q_exp[$];
    int          q_stamp[$];
    string       q_tag[$];

    fp32_addsub u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .op_sub    (op_sub),
        .out_valid (out_valid),
        .result    (result),
        .ovf_flag  (ovf_flag),
        .unf_flag  (unf_flag)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic send(input logic [31:0] a, input logic [31:0] b, input logic s,
                        input logic [31:0] er, input logic eo, input logic eu, input string tag);
        @(negedge clk);
        op_a = a; op_b = b; op_sub = s; in_valid = 1'b1;
        q_exp.push_back({er, eo, eu});
        q_stamp.push_back(cyc);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_chk++;
            if (q_exp.size() == 0) begin
                n_bad++;
                $display("FAIL R1 unexpected result: got %h expected no output", result);
            end else begin
                logic [33:0] ex;
                int st;
                string tg;
                ex = q_exp.pop_front();
                st = q_stamp.pop_front();
                tg = q_tag.pop_front();
                if ({result, ovf_flag, unf_flag} !== ex) begin
                    n_bad++;
                    $display("FAIL %s: got %h ovf=%b unf=%b expected %h ovf=%b unf=%b",
                             tg, result, ovf_flag, unf_flag, ex[33:2], ex[1], ex[0]);
                end
                n_chk++;
                if (cyc != st + 3) begin
                    n_bad++;
                    $display("FAIL R1 latency (%s): got %0d expected %0d", tg, cyc - st, 3);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || ovf_flag !== 1'b0 || unf_flag !== 1'b0) begin
            n_bad++;
            $display("FAIL R11 in reset: got %b%b%b expected 000", out_valid, ovf_flag, unf_flag);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || ovf_flag !== 1'b0 || unf_flag !== 1'b0) begin
            n_bad++;
            $display("FAIL R11 after reset: got %b%b%b expected 000", out_valid, ovf_flag, unf_flag);
        end

        // back-to-back stream
        send(32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, 1'b0, 1'b0, "R2 1+1");
        send(32'h3FC00000, 32'h3F000000, 1'b1, 32'h3F800000, 1'b0, 1'b0, "R2 1.5-0.5");
        send(32'h40E00000, 32'h40C00000, 1'b0, 32'h41500000, 1'b0, 1'b0, "R2 7+6");
        send(32'h3F800000, 32'h40000000, 1'b1, 32'hBF800000, 1'b0, 1'b0, "R2 1-2");
        send(32'h3F000000, 32'hBEE00000, 1'b0, 32'h3D800000, 1'b0, 1'b0, "R5 0.5-0.4375");
        send(32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 1'b0, 1'b0, "R3 tie even down");
        send(32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 1'b0, 1'b0, "R3 tie odd up");
        send(32'h3FFFFFFF, 32'h33800000, 1'b0, 32'h40000000, 1'b0, 1'b0, "R4 round carry");
        idle(2);
        send(32'h7F7FFFFF, 32'h73000000, 1'b0, 32'h7F800000, 1'b1, 1'b0, "R7 round to inf");
        send(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 1'b1, 1'b0, "R7 +ovf");
        send(32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, 32'hFF800000, 1'b1, 1'b0, "R7 -ovf");
        send(32'h3F800000, 32'h3F800000, 1'b1, 32'h00000000, 1'b0, 1'b0, "R5 x-x");
        send(32'h80000000, 32'h80000000, 1'b0, 32'h80000000, 1'b0, 1'b0, "R5 -0+-0");
        send(32'h00000000, 32'h80000000, 1'b0, 32'h00000000, 1'b0, 1'b0, "R5 +0+-0");
        send(32'h80000000, 32'h00000000, 1'b1, 32'h80000000, 1'b0, 1'b0, "R5 -0-+0");
        idle(1);
        send(32'h00000001, 32'h00000001, 1'b0, 32'h00000002, 1'b0, 1'b1, "R6 sub+sub");
        send(32'h00400000, 32'h00400000, 1'b0, 32'h00800000, 1'b0, 1'b0, "R6 to normal");
        send(32'h00800000, 32'h00000001, 1'b1, 32'h007FFFFF, 1'b0, 1'b1, "R6 normal-sub");
        send(32'h7F800000, 32'h3F800000, 1'b0, 32'h7F800000, 1'b0, 1'b0, "R8 inf+1");
        send(32'h7F800000, 32'h7F800000, 1'b1, 32'h7FC00000, 1'b0, 1'b0, "R8 inf-inf");
        send(32'hFF800000, 32'hFF800000, 1'b0, 32'hFF800000, 1'b0, 1'b0, "R8 -inf+-inf");
        send(32'h3F800000, 32'h7F800000, 1'b1, 32'hFF800000, 1'b0, 1'b0, "R8 1-inf");
        send(32'h7F800001, 32'h3F800000, 1'b0, 32'h7FC00000, 1'b0, 1'b0, "R9 nan a");
        send(32'h3F800000, 32'hFFC12345, 1'b1, 32'h7FC00000, 1'b0, 1'b0, "R9 nan b");
        send(32'h7FC00000, 32'h7F800000, 1'b0, 32'h7FC00000, 1'b0, 1'b0, "R9 nan+inf");
        idle(3);
        send(32'h3F800000, 32'h00000001, 1'b0, 32'h3F800000, 1'b0, 1'b0, "R10 far add");
        send(32'h3F800000, 32'h00000001, 1'b1, 32'h3F800000, 1'b0, 1'b0, "R10 far sub");
        send(32'h3F800000, 32'h33000000, 1'b1, 32'h3F800000, 1'b0, 1'b0, "R10 sub tie");
        send(32'h4B800000, 32'h3F800000, 1'b0, 32'h4B800000, 1'b0, 1'b0, "R10 2^24+1");
        idle(8);

        n_chk++;
        if (q_exp.size() != 0) begin
            n_bad++;
            $display("FAIL R1 missing results: got %0d pending expected 0", q_exp.size());
        end
        finish_run();
    end
endmodule